// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a down-counting supervision timer. A prescaler divides the peripheral clock by one of six ratios, and the counter steps down once per prescaled tick from a selectable period. Software proves it is alive by writing a two-step key to the refresh register. The key is accepted only while the counter sits inside a refresh window. The window is bounded by an opening point and a closing point, each a quarter-step fraction of the period.

A fault is either an underflow or a key completed outside the window. Each kind sets its own sticky status bit. The fault then takes one of two actions, chosen by a configuration bit:

- **Reset action:** a level reset request that is held until the next reset.
- **Interrupt action:** a one-cycle non-maskable interrupt request. The counter halts until software completes a new key.

A low-power input can freeze counting if the configuration asks for it. Software can read the counter value at any time.

The controller is a four-state machine:

- **IDLE:** not started. Configuration is writable.
- **LAUNCH:** one cycle that loads the full period.
- **RUN:** counting.
- **HALT:** stopped after a fault.

The transitions are:

- Reset goes to LAUNCH when the auto-start option input is high. Otherwise it goes to IDLE.
- IDLE goes to LAUNCH on a start write.
- LAUNCH always goes to RUN.
- RUN goes to HALT on any fault.
- HALT goes to LAUNCH on a completed key, but only under the interrupt action.

Top module: `wwdt_top`

## Requirements
- R1: After reset with `opt_auto` low, the block is idle with these values: the control register (address 0) reads 0x035, start (address 1) reads 0, status (address 3) reads 0, count (address 4) reads 0, and `rst_req` and `nmi_req` are low.
- R2: Control register fields:
  - Bits 2:0 select the prescale ratio: code 0 is /4, 1 is /64, 2 is /128, 3 is /512, 4 is /2048, and 5 to 7 are /8192.
  - Bits 5:4 select the period: code 0 is 1024, 1 is 4096, 2 is 8192, 3 is 16384.

  Writing 1 to bit 0 of address 1 starts the counter. It loads period-1 and then decrements once per prescaled tick. Address 4 always returns the counter value.
- R3: With `opt_auto` high during reset, the control register takes `opt_cfg` and counting starts with no register write.
- R4: If no refresh is accepted, the counter reaches 0 and the next tick is an underflow. The underflow sets status bit 0 and triggers the fault action.
- R5: A refresh needs two writes to address 2, in this order: 0x00, then 0xFF. If the counter is in the window, it reloads period-1 on the cycle after the second write. Any other value, or any other order, reloads nothing.
- R6: Window fields of the control register:
  - Bits 7:6 set the window opening: code 0 is 100%, 1 is 75%, 2 is 50%, 3 is 25% of the period.
  - Bits 9:8 set the window closing: code 0 is 0%, 1 is 25%, 2 is 50%, 3 is 75%.

  A completed key is valid only if the count is below the opening point and at or above the closing point. Otherwise it sets status bit 1 and triggers the fault action.
- R7: Fault action, selected by control bit 10:
  - At 0, `rst_req` rises and stays high until reset.
  - At 1, `nmi_req` pulses for one cycle. The counter then halts, and a later completed key restarts it from period-1.
- R8: Low-power control is bit 11. At 0, the counter holds its value while `lp_in` is high. At 1, it keeps counting.
- R9: The two status bits are sticky and independent. Writing 1 to a bit position of address 3 clears that bit.
- R10: Once started, writes to the control and start registers are ignored until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset; option inputs are sampled while it is low |
| opt_auto | input | 1 | Option word: start automatically after reset |
| opt_cfg | input | 12 | Option word: control-register image used in auto-start |
| lp_in | input | 1 | Low-power indication |
| req_valid | input | 1 | Register access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register address |
| req_wdata | input | 16 | Write data |
| rd_data | output | 16 | Read data for the addressed register (combinational) |
| rst_req | output | 1 | Held reset request after a fault |
| nmi_req | output | 1 | One-cycle non-maskable interrupt request after a fault |

## Verification
The hardest case to reach is a refresh that lands on the right side of a narrowed window. The valid region is bounded on both sides and moves only once per prescaled tick, so the stimulus must place the key inside it.

The bench uses the fastest prescale ratio and the shortest period, then counts idle cycles from a known reload point. This puts one key well above the opening point, one between the two points, and one below the closing point.

The interrupt action is needed to get past the first refresh error. That error halts the counter, and the restart key then gives a fresh reload point from which the later keys are timed.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;

    localparam int CFG_W = 12;
    localparam int PS_W  = 14;
    localparam int CNT_W = 15;

    localparam int A_CTRL  = 0;
    localparam int A_START = 1;
    localparam int A_KICK  = 2;
    localparam int A_STAT  = 3;
    localparam int A_COUNT = 4;

    localparam logic [7:0] KEY_ARM  = 8'h00;
    localparam logic [7:0] KEY_FIRE = 8'hFF;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_RUN,
        ST_HALT
    } wd_state_e;

    typedef struct packed {
        logic       lp_run;
        logic       act_nmi;
        logic [1:0] close_sel;
        logic [1:0] open_sel;
        logic [1:0] tmo_sel;
        logic       rsvd;
        logic [2:0] div_sel;
    } wd_cfg_t;

    localparam logic [CFG_W-1:0] CFG_DEFAULT = 12'h035;

    function automatic logic [PS_W-1:0] div_ratio(input logic [2:0] sel);
        case (sel)
            3'd0:    div_ratio = PS_W'(4);
            3'd1:    div_ratio = PS_W'(64);
            3'd2:    div_ratio = PS_W'(128);
            3'd3:    div_ratio = PS_W'(512);
            3'd4:    div_ratio = PS_W'(2048);
            default: div_ratio = PS_W'(8192);
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] tmo_cycles(input logic [1:0] sel);
        case (sel)
            2'd0:    tmo_cycles = CNT_W'(1024);
            2'd1:    tmo_cycles = CNT_W'(4096);
            2'd2:    tmo_cycles = CNT_W'(8192);
            default: tmo_cycles = CNT_W'(16384);
        endcase
    endfunction

endpackage

// File: rtl/wwdt_prescale.sv
module wwdt_prescale
    import wwdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic [2:0] div_sel,
    output logic       tick
);

    logic [PS_W-1:0] pcnt;
    logic [PS_W-1:0] last;

    assign last = div_ratio(div_sel) - PS_W'(1);
    assign tick = en && !clr && (pcnt == last);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (clr) begin
            pcnt <= '0;
        end else if (en) begin
            pcnt <= (pcnt == last) ? '0 : pcnt + PS_W'(1);
        end
    end

    // R8: a disabled prescaler does not advance
    assert_presc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(pcnt));

endmodule

// File: rtl/wwdt_counter.sv
module wwdt_counter
    import wwdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             en,
    input  logic             tick,
    input  logic [1:0]       tmo_sel,
    input  logic [1:0]       open_sel,
    input  logic [1:0]       close_sel,
    output logic [CNT_W-1:0] count,
    output logic             in_window,
    output logic             at_zero
);

    logic [CNT_W-1:0] full;
    logic [CNT_W-1:0] quarter;
    logic [CNT_W-1:0] open_lim;
    logic [CNT_W-1:0] close_lim;

    assign full    = tmo_cycles(tmo_sel);
    assign quarter = full >> 2;

    always_comb begin
        case (open_sel)
            2'd0:    open_lim = full;
            2'd1:    open_lim = quarter + (quarter << 1);
            2'd2:    open_lim = quarter << 1;
            default: open_lim = quarter;
        endcase
        case (close_sel)
            2'd0:    close_lim = '0;
            2'd1:    close_lim = quarter;
            2'd2:    close_lim = quarter << 1;
            default: close_lim = quarter + (quarter << 1);
        endcase
    end

    assign in_window = (count < open_lim) && (count >= close_lim);
    assign at_zero   = (count == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= full - CNT_W'(1);
        end else if (en && tick && !at_zero) begin
            count <= count - CNT_W'(1);
        end
    end

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (count < full));

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (count == $past(count)) || (count == $past(count) - CNT_W'(1)));

    assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !load) |=> $stable(count));

endmodule

// File: rtl/wwdt_ctrl.sv
module wwdt_ctrl
    import wwdt_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              opt_auto,
    input  logic [CFG_W-1:0]  opt_cfg,
    input  logic              lp_in,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              in_window,
    input  logic              at_zero,
    input  logic              tick,
    output wd_cfg_t           cfg,
    output logic              load,
    output logic              cnt_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rst_req,
    output logic              nmi_req
);

    wd_state_e state_q, state_d;

    logic wr, wr_ctrl, wr_start, wr_kick, wr_stat;
    logic armed_q, kick_pend_q;
    logic kick_ok, fault_unf, fault_rerr, fault;
    logic flag_unf_q, flag_rerr_q;
    logic wdata_unused;

    assign wdata_unused = ^req_wdata[DATA_W-1:CFG_W];

    assign wr       = req_valid && req_write;
    assign wr_ctrl  = wr && (req_addr == ADDR_W'(A_CTRL))  && (state_q == ST_IDLE);
    assign wr_start = wr && (req_addr == ADDR_W'(A_START)) && (state_q == ST_IDLE) && req_wdata[0];
    assign wr_kick  = wr && (req_addr == ADDR_W'(A_KICK));
    assign wr_stat  = wr && (req_addr == ADDR_W'(A_STAT));

    assign kick_ok    = (state_q == ST_RUN) && kick_pend_q && in_window;
    assign fault_rerr = (state_q == ST_RUN) && kick_pend_q && !in_window;
    assign fault_unf  = (state_q == ST_RUN) && tick && at_zero && !kick_ok;
    assign fault      = fault_unf || fault_rerr;

    assign load   = (state_q == ST_LAUNCH) || kick_ok;
    assign cnt_en = (state_q == ST_RUN) && !(lp_in && !cfg.lp_run);

    // configuration: option word at reset, register writes only while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= opt_auto ? wd_cfg_t'(opt_cfg) : wd_cfg_t'(CFG_DEFAULT);
        end else if (wr_ctrl) begin
            cfg <= wd_cfg_t'(req_wdata[CFG_W-1:0]);
        end
    end

    // two-write refresh key
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q     <= 1'b0;
            kick_pend_q <= 1'b0;
        end else begin
            kick_pend_q <= 1'b0;
            if (wr_kick) begin
                if (req_wdata[7:0] == KEY_ARM) begin
                    armed_q <= 1'b1;
                end else begin
                    armed_q     <= 1'b0;
                    kick_pend_q <= armed_q && (req_wdata[7:0] == KEY_FIRE);
                end
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= opt_auto ? ST_LAUNCH : ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (wr_start) state_d = ST_LAUNCH;
            ST_LAUNCH: state_d = ST_RUN;
            ST_RUN:    if (fault) state_d = ST_HALT;
            ST_HALT:   if (cfg.act_nmi && kick_pend_q) state_d = ST_LAUNCH;
        endcase
    end

    // outputs and status flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req     <= 1'b0;
            nmi_req     <= 1'b0;
            flag_unf_q  <= 1'b0;
            flag_rerr_q <= 1'b0;
        end else begin
            rst_req <= rst_req || (fault && !cfg.act_nmi);
            nmi_req <= fault && cfg.act_nmi;
            if (fault_unf) begin
                flag_unf_q <= 1'b1;
            end else if (wr_stat && req_wdata[0]) begin
                flag_unf_q <= 1'b0;
            end
            if (fault_rerr) begin
                flag_rerr_q <= 1'b1;
            end else if (wr_stat && req_wdata[1]) begin
                flag_rerr_q <= 1'b0;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        case (req_addr)
            ADDR_W'(A_CTRL):  rd_data[CFG_W-1:0] = cfg;
            ADDR_W'(A_START): rd_data[0] = (state_q != ST_IDLE);
            ADDR_W'(A_STAT):  rd_data[1:0] = {flag_rerr_q, flag_unf_q};
            ADDR_W'(A_COUNT): rd_data[CNT_W-1:0] = count;
            default:          rd_data = '0;
        endcase
    end

    assert_cfg_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(cfg));

    assert_rst_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);

    assert_nmi_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |=> !nmi_req);

    assert_unf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_unf_q && !(wr_stat && req_wdata[0])) |=> flag_unf_q);

    assert_rerr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rerr_q && !(wr_stat && req_wdata[1])) |=> flag_rerr_q);

endmodule

// File: rtl/wwdt_top.sv
module wwdt_top
    import wwdt_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              opt_auto,
    input  logic [CFG_W-1:0]  opt_cfg,
    input  logic              lp_in,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rst_req,
    output logic              nmi_req
);

    wd_cfg_t          cfg;
    logic             load, cnt_en, tick, in_window, at_zero;
    logic [CNT_W-1:0] count;
    logic             cfg_unused;

    assign cfg_unused = cfg.rsvd;

    wwdt_prescale u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (load),
        .en      (cnt_en),
        .div_sel (cfg.div_sel),
        .tick    (tick)
    );

    wwdt_counter u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .en        (cnt_en),
        .tick      (tick),
        .tmo_sel   (cfg.tmo_sel),
        .open_sel  (cfg.open_sel),
        .close_sel (cfg.close_sel),
        .count     (count),
        .in_window (in_window),
        .at_zero   (at_zero)
    );

    wwdt_ctrl #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .opt_auto  (opt_auto),
        .opt_cfg   (opt_cfg),
        .lp_in     (lp_in),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .count     (count),
        .in_window (in_window),
        .at_zero   (at_zero),
        .tick      (tick),
        .cfg       (cfg),
        .load      (load),
        .cnt_en    (cnt_en),
        .rd_data   (rd_data),
        .rst_req   (rst_req),
        .nmi_req   (nmi_req)
    );

endmodule

// File: tb/wwdt_top_bench.sv
module wwdt_top_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        opt_auto = 1'b0;
    logic [11:0] opt_cfg = 12'h000;
    logic        lp_in = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [2:0]  req_addr = 3'd0;
    logic [15:0] req_wdata = 16'h0;
    logic [15:0] rd_data;
    logic        rst_req;
    logic        nmi_req;

    always #(CLK_PERIOD/2) clk = ~clk;

    wwdt_top u_wwdt_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .opt_auto  (opt_auto),
        .opt_cfg   (opt_cfg),
        .lp_in     (lp_in),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rd_data   (rd_data),
        .rst_req   (rst_req),
        .nmi_req   (nmi_req)
    );

    typedef struct {
        int    lo;
        int    hi;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t mon_item;

    int mon_checks = 0, mon_errs = 0;
    int drv_checks = 0, drv_errs = 0;
    int nmi_cnt = 0, nmi_base = 0;
    bit done = 1'b0;

    // monitor: pops expected read results and compares them
    always @(negedge clk) begin
        if (rst_n && nmi_req) nmi_cnt++;
        if (req_valid && !req_write && exp_q.size() > 0) begin
            mon_item = exp_q.pop_front();
            mon_checks++;
            if (int'(rd_data) < mon_item.lo || int'(rd_data) > mon_item.hi) begin
                mon_errs++;
                $display("FAIL %s: actual %0d expected %0d..%0d",
                         mon_item.tag, rd_data, mon_item.lo, mon_item.hi);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        drv_checks++;
        if (act != exp) begin
            drv_errs++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = 1'b1;
        req_addr = 3'(addr); req_wdata = 16'(data);
        @(posedge clk); #1;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd_exp(input int addr, input int lo, input int hi, input string tag);
        exp_t e;
        e.lo = lo; e.hi = hi; e.tag = tag;
        @(posedge clk); #1;
        exp_q.push_back(e);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 3'(addr);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic peek_count(output int v);
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 3'd4;
        @(negedge clk);
        v = int'(rd_data);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic kick();
        wr(2, 'h00);
        wr(2, 'hFF);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic do_reset(input bit auto_on, input int cfgw);
        @(posedge clk); #1;
        rst_n = 1'b0; opt_auto = auto_on; opt_cfg = 12'(cfgw); lp_in = 1'b0;
        idle(4); #1;
        rst_n = 1'b1;
        nmi_base = nmi_cnt;
    endtask

    task automatic summary(input int extra);
        $display("Simulation finished: %0d checks, %0d errors",
                 mon_checks + drv_checks + extra, mon_errs + drv_errs + extra);
    endtask

    initial begin
        int snap;
        // R1 reset state
        do_reset(1'b0, 'h000);
        rd_exp(0, 'h035, 'h035, "R1 ctrl default");
        rd_exp(1, 0, 0, "R1 not started");
        rd_exp(3, 0, 0, "R1 status clear");
        rd_exp(4, 0, 0, "R1 count zero");
        chk("R1 rst_req low", int'(rst_req), 0);
        chk("R1 nmi_req low", int'(nmi_req), 0);

        // R2 register start, /4, 1024, NMI action
        wr(0, 'h400);
        wr(1, 1);
        rd_exp(4, 1021, 1023, "R2 loaded period-1");
        rd_exp(1, 1, 1, "R2 started");
        idle(400);
        rd_exp(4, 918, 926, "R2 decrement per tick");
        // R10 write protection
        wr(0, 'h035);
        wr(1, 0);
        rd_exp(0, 'h400, 'h400, "R10 ctrl locked");
        rd_exp(1, 1, 1, "R10 start locked");

        // R5 bad key sequences
        wr(2, 'hFF);
        wr(2, 'h00);
        wr(2, 'h55);
        wr(2, 'hFF);
        idle(2);
        rd_exp(4, 850, 930, "R5 bad key ignored");
        rd_exp(3, 0, 0, "R5 bad key no fault");
        kick();
        idle(1);
        rd_exp(4, 1019, 1023, "R5 good key reloads");

        // R8 freeze in low power
        @(posedge clk); #1; lp_in = 1'b1;
        idle(2);
        peek_count(snap);
        idle(200);
        rd_exp(4, snap, snap, "R8 frozen in low power");
        @(posedge clk); #1; lp_in = 1'b0;

        // R4 underflow with NMI action
        idle(4300);
        chk("R7 one nmi pulse", nmi_cnt - nmi_base, 1);
        chk("R7 no reset in nmi mode", int'(rst_req), 0);
        rd_exp(3, 1, 1, "R4 underflow flag");
        rd_exp(4, 0, 0, "R7 halted count");
        idle(50);
        rd_exp(4, 0, 0, "R7 still halted");
        wr(3, 1);
        rd_exp(3, 0, 0, "R9 flag cleared");
        kick();
        idle(3);
        rd_exp(4, 1017, 1023, "R7 restart after nmi");

        // R6 window 50%..25%
        do_reset(1'b0, 'h000);
        wr(0, 'h580);
        wr(1, 1);
        idle(5);
        kick();
        idle(3);
        rd_exp(3, 2, 2, "R6 early refresh error flag");
        chk("R6 early refresh nmi", nmi_cnt - nmi_base, 1);
        wr(3, 3);
        rd_exp(3, 0, 0, "R9 clear by mask");
        kick();
        idle(2480);
        kick();
        idle(2);
        rd_exp(4, 1015, 1023, "R6 refresh inside window");
        rd_exp(3, 0, 0, "R6 inside window no flag");
        chk("R6 inside window no nmi", nmi_cnt - nmi_base, 1);
        idle(3300);
        kick();
        idle(3);
        rd_exp(3, 2, 2, "R6 late refresh error flag");
        chk("R6 late refresh nmi", nmi_cnt - nmi_base, 2);

        // R7 reset action
        do_reset(1'b0, 'h000);
        wr(0, 'h000);
        wr(1, 1);
        idle(4200);
        chk("R7 reset asserted", int'(rst_req), 1);
        chk("R7 no nmi in reset mode", nmi_cnt - nmi_base, 0);
        rd_exp(3, 1, 1, "R4 underflow flag reset mode");
        kick();
        idle(20);
        chk("R7 reset held", int'(rst_req), 1);

        // R3 auto start with lp_run set, /64
        do_reset(1'b1, 'h801);
        rd_exp(0, 'h801, 'h801, "R3 option cfg latched");
        rd_exp(1, 1, 1, "R3 running without write");
        idle(640);
        rd_exp(4, 1008, 1016, "R3 counting after auto start");
        @(posedge clk); #1; lp_in = 1'b1;
        idle(640);
        rd_exp(4, 996, 1007, "R8 counts in low power when enabled");
        @(posedge clk); #1; lp_in = 1'b0;
        wr(0, 'h035);
        rd_exp(0, 'h801, 'h801, "R10 auto cfg locked");

        wait (exp_q.size() == 0);
        idle(2);
        done = 1'b1;
        summary(0);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog: actual hung expected completion");
            summary(1);
            $finish;
        end
    end

endmodule